// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and turns them into two processor interrupt outputs: a fast-interrupt line and a normal-interrupt line. Each output has its own enable mask over the same raw sources. A request that is high and enabled in a mask drives the matching output high. When no enabled request is high, the output goes low.

Software reaches the block through a single-cycle register port: address, write strobe, write data, access size and read data. Read data is combinational from the address. There is no handshake, so the port never stalls and there is no back-pressure. The masks can be changed only through separate set and clear addresses, where each one-bit in the write data sets or clears the matching mask bit. The request lines are sampled level inputs and must already be synchronous to `clk`.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A word read at offset 0x00 returns the current request lines `req_i`, bit for bit, with no latching.
- R2: A word read at 0x04 returns `req_i` ANDed with the fast mask, and a word read at 0x08 returns `req_i` ANDed with the normal mask.
- R3: `fiq_o` is registered. After each rising edge it equals the OR of (`req_i` AND fast mask) as it stood before that edge. `irq_o` behaves the same way with the normal mask.
- R4: A word read at 0x0C returns the fast mask and one at 0x10 returns the normal mask. Word reads at 0x14, at 0x18 and at any other address return zero.
- R5: A word write to 0x0C ORs the write data into the fast mask, and one to 0x10 ORs it into the normal mask. The new mask is readable from the next cycle.
- R6: A word write to 0x14 clears the fast-mask bits where the write data is one, and one to 0x18 does the same for the normal mask.
- R7: Writes to 0x00, 0x04, 0x08, to a misaligned address or to any unmapped address change neither mask.
- R8: `acc_size` encodes 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 reserved. Only word accesses act: any other size reads zero and its writes are ignored.
- R9: While `rst_n` is low at a rising edge, both masks become zero and both outputs go low.
- R10: A write to one output's set or clear address leaves the other output's mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_SRC | Level request lines, synchronous to clk |
| acc_addr | input | ADDR_W | Register byte offset |
| acc_size | input | 2 | Access size code (byte, halfword, word, reserved) |
| acc_wr | input | 1 | Write strobe for the current cycle |
| wr_data | input | NUM_SRC | Write data |
| rd_data | output | NUM_SRC | Combinational read data for acc_addr |
| fiq_o | output | 1 | Fast interrupt level output |
| irq_o | output | 1 | Normal interrupt level output |

## Verification
A mask bit that is wrongly set or cleared shows at the port in the same cycle as a word read of its enable address or its status address. It reaches the matching output one edge later, provided that source is requesting. A missing or doubled output register shows as a response to a request change that comes one edge early or one edge late. A decode that lets a status, misaligned or narrow write through shows up on the next read of either mask. The bench places every check at the cycle where the change should first be visible, and also one cycle earlier where the output must not have moved yet.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_RAW,
    RD_STAT,
    RD_MASK
  } rd_kind_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_FIQ = 0;
  localparam int unsigned CH_IRQ = 1;

  localparam int unsigned OFS_RAW  = 'h00;
  localparam int unsigned OFS_FSTA = 'h04;
  localparam int unsigned OFS_ISTA = 'h08;
  localparam int unsigned OFS_FSET = 'h0C;
  localparam int unsigned OFS_ISET = 'h10;
  localparam int unsigned OFS_FCLR = 'h14;
  localparam int unsigned OFS_ICLR = 'h18;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              wr_i,
  output logic [NUM_CH-1:0] set_stb_o,
  output logic [NUM_CH-1:0] clr_stb_o,
  output rd_kind_e          rd_kind_o,
  output logic              rd_ch_o
);
  logic word_acc;
  assign word_acc = (size_i == SZ_WORD);

  always_comb begin
    set_stb_o = '0;
    clr_stb_o = '0;
    rd_kind_o = RD_ZERO;
    rd_ch_o   = 1'b0;
    if (word_acc) begin
      case (addr_i)
        ADDR_W'(OFS_RAW):  rd_kind_o = RD_RAW;
        ADDR_W'(OFS_FSTA): begin rd_kind_o = RD_STAT; rd_ch_o = 1'(CH_FIQ); end
        ADDR_W'(OFS_ISTA): begin rd_kind_o = RD_STAT; rd_ch_o = 1'(CH_IRQ); end
        ADDR_W'(OFS_FSET): begin
          rd_kind_o = RD_MASK; rd_ch_o = 1'(CH_FIQ); set_stb_o[CH_FIQ] = wr_i;
        end
        ADDR_W'(OFS_ISET): begin
          rd_kind_o = RD_MASK; rd_ch_o = 1'(CH_IRQ); set_stb_o[CH_IRQ] = wr_i;
        end
        ADDR_W'(OFS_FCLR): clr_stb_o[CH_FIQ] = wr_i;
        ADDR_W'(OFS_ICLR): clr_stb_o[CH_IRQ] = wr_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_o <= '0;
    else if (set_i) mask_o <= mask_o | data_i;
    else if (clr_i) mask_o <= mask_o & ~data_i;
  end
endmodule

// File: rtl/irqc_level.sv
module irqc_level #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  output logic         lvl_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_o <= 1'b0;
    else        lvl_o <= |stat_i;
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         acc_size,
  input  logic               acc_wr,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] rd_data,
  output logic               fiq_o,
  output logic               irq_o
);
  logic [NUM_CH-1:0]              set_stb;
  logic [NUM_CH-1:0]              clr_stb;
  rd_kind_e                       rd_kind;
  logic                           rd_ch;
  logic [NUM_CH-1:0][NUM_SRC-1:0] mask;
  logic [NUM_CH-1:0][NUM_SRC-1:0] stat;
  logic [NUM_CH-1:0]              lvl;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(acc_addr), .size_i(acc_size), .wr_i(acc_wr),
    .set_stb_o(set_stb), .clr_stb_o(clr_stb),
    .rd_kind_o(rd_kind), .rd_ch_o(rd_ch)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    irqc_mask #(.W(NUM_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_stb[ch]), .clr_i(clr_stb[ch]),
      .data_i(wr_data), .mask_o(mask[ch])
    );
    assign stat[ch] = req_i & mask[ch];
    irqc_level #(.W(NUM_SRC)) u_lvl (
      .clk(clk), .rst_n(rst_n), .stat_i(stat[ch]), .lvl_o(lvl[ch])
    );
  end

  assign fiq_o = lvl[CH_FIQ];
  assign irq_o = lvl[CH_IRQ];

  always_comb begin
    case (rd_kind)
      RD_RAW:  rd_data = req_i;
      RD_STAT: rd_data = stat[rd_ch];
      RD_MASK: rd_data = mask[rd_ch];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [1:0]         acc_size,
  input logic               acc_wr,
  input logic [NUM_SRC-1:0] wr_data,
  input logic [NUM_SRC-1:0] rd_data,
  input logic               fiq_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] fen,
  input logic [NUM_SRC-1:0] ien
);
  logic armed;
  logic saw_reset = 1'b0;
  logic wword, w_fset, w_iset, w_fclr, w_iclr, w_f_any, w_i_any;

  always_ff @(posedge clk) begin
    armed     <= rst_n;
    saw_reset <= !rst_n;
  end

  assign wword   = acc_wr && (acc_size == SZ_WORD);
  assign w_fset  = wword && (acc_addr == ADDR_W'(OFS_FSET));
  assign w_iset  = wword && (acc_addr == ADDR_W'(OFS_ISET));
  assign w_fclr  = wword && (acc_addr == ADDR_W'(OFS_FCLR));
  assign w_iclr  = wword && (acc_addr == ADDR_W'(OFS_ICLR));
  assign w_f_any = w_fset || w_fclr;
  assign w_i_any = w_iset || w_iclr;

  p_raw_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == SZ_WORD && acc_addr == ADDR_W'(OFS_RAW)) |-> rd_data == req_i);

  p_fiq_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> fiq_o == $past(|(req_i & fen)));

  p_irq_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_o == $past(|(req_i & ien)));

  p_fen_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_fset |=> fen == $past(fen | wr_data));

  p_ien_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_iset |=> ien == $past(ien | wr_data));

  p_fen_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    w_fclr |=> fen == $past(fen & ~wr_data));

  p_ien_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    w_iclr |=> ien == $past(ien & ~wr_data));

  p_hold_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !w_f_any && !w_i_any) |=> ($stable(fen) && $stable(ien)));

  p_narrow_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size != SZ_WORD) |-> rd_data == '0);

  p_cross_fiq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    w_f_any |=> $stable(ien));

  p_cross_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    w_i_any |=> $stable(fen));

  always @(negedge clk) begin
    if (saw_reset) begin
      p_reset_state_r9: assert (fen == '0 && ien == '0 && !fiq_o && !irq_o);
    end
  end
endmodule

bind dual_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_addr(acc_addr),
  .acc_size(acc_size), .acc_wr(acc_wr), .wr_data(wr_data), .rd_data(rd_data),
  .fiq_o(fiq_o), .irq_o(irq_o), .fen(mask[0]), .ien(mask[1])
);

// File: tb/tb_dual_irq_ctrl.sv
module tb_dual_irq_ctrl;
  import irqc_pkg::*;

  localparam int unsigned NS = 32;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req_i = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = SZ_WORD;
  logic          acc_wr = 1'b0;
  logic [NS-1:0] wr_data = '0;
  logic [NS-1:0] rd_data;
  logic          fiq_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_irq_ctrl #(.NUM_SRC(NS), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wr(acc_wr), .wr_data(wr_data),
    .rd_data(rd_data), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [NS-1:0] got, input logic [NS-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int unsigned a, input logic [NS-1:0] d, input logic [1:0] sz);
    @(negedge clk);
    acc_addr = AW'(a); acc_size = sz; wr_data = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; acc_size = SZ_WORD;
  endtask

  task automatic rd(input int unsigned a, input logic [1:0] sz, output logic [NS-1:0] d);
    acc_addr = AW'(a); acc_size = sz; acc_wr = 1'b0;
    #1 d = rd_data;
    acc_size = SZ_WORD;
  endtask

  task automatic t_reset();
    logic [NS-1:0] d;
    req_i = '1;
    repeat (3) step();
    check("R9 fiq_o in reset", NS'(fiq_o), '0);
    check("R9 irq_o in reset", NS'(irq_o), '0);
    rd(OFS_FSET, SZ_WORD, d); check("R9 fast mask after reset", d, '0);
    rd(OFS_ISET, SZ_WORD, d); check("R9 normal mask after reset", d, '0);
    rst_n = 1'b1;
    step();
    check("R9 fiq_o stays low with empty mask", NS'(fiq_o), '0);
  endtask

  task automatic t_raw();
    logic [NS-1:0] d;
    req_i = 32'hA5A5_3C3C;
    rd(OFS_RAW, SZ_WORD, d); check("R1 raw read A", d, 32'hA5A5_3C3C);
    req_i = 32'h0000_0001;
    rd(OFS_RAW, SZ_WORD, d); check("R1 raw read follows level", d, 32'h0000_0001);
    req_i = '0;
  endtask

  task automatic t_set_masks();
    logic [NS-1:0] d;
    wr(OFS_FSET, 32'h0000_00F0, SZ_WORD);
    rd(OFS_FSET, SZ_WORD, d); check("R5 fast mask set", d, 32'h0000_00F0);
    wr(OFS_FSET, 32'h0000_0F00, SZ_WORD);
    rd(OFS_FSET, SZ_WORD, d); check("R5 fast mask OR", d, 32'h0000_0FF0);
    rd(OFS_ISET, SZ_WORD, d); check("R10 normal mask untouched", d, '0);
  endtask

  task automatic t_status_level();
    logic [NS-1:0] d;
    req_i = 32'h0000_0031;
    rd(OFS_FSTA, SZ_WORD, d); check("R2 fast status", d, 32'h0000_0030);
    rd(OFS_ISTA, SZ_WORD, d); check("R2 normal status", d, '0);
    #1 check("R3 fiq_o not yet high before edge", NS'(fiq_o), '0);
    step();
    check("R3 fiq_o high one edge later", NS'(fiq_o), 1);
    check("R3 irq_o low with empty mask", NS'(irq_o), '0);
    req_i = '0;
    #1 check("R3 fiq_o still high before edge", NS'(fiq_o), 1);
    step();
    check("R3 fiq_o low after request drops", NS'(fiq_o), '0);
  endtask

  task automatic t_clear();
    logic [NS-1:0] d;
    wr(OFS_FCLR, 32'h0000_00F0, SZ_WORD);
    rd(OFS_FSET, SZ_WORD, d); check("R6 fast mask clear", d, 32'h0000_0F00);
    rd(OFS_FCLR, SZ_WORD, d); check("R4 read of fast clear is zero", d, '0);
    rd(OFS_ICLR, SZ_WORD, d); check("R4 read of normal clear is zero", d, '0);
    rd('h20, SZ_WORD, d);     check("R4 read of unmapped is zero", d, '0);
  endtask

  task automatic t_irq_path();
    logic [NS-1:0] d;
    wr(OFS_ISET, 32'h8000_0001, SZ_WORD);
    rd(OFS_ISET, SZ_WORD, d); check("R5 normal mask set", d, 32'h8000_0001);
    rd(OFS_FSET, SZ_WORD, d); check("R10 fast mask untouched", d, 32'h0000_0F00);
    req_i = 32'h8000_0000;
    step();
    check("R3 irq_o high", NS'(irq_o), 1);
    check("R3 fiq_o low (source not in fast mask)", NS'(fiq_o), '0);
    wr(OFS_ICLR, 32'h8000_0000, SZ_WORD);
    rd(OFS_ISET, SZ_WORD, d); check("R6 normal mask clear", d, 32'h0000_0001);
    check("R3 irq_o still high one cycle after clear", NS'(irq_o), 1);
    step();
    check("R6 irq_o low after mask clear", NS'(irq_o), '0);
    req_i = '0;
  endtask

  task automatic t_ignored();
    logic [NS-1:0] d;
    wr(OFS_RAW,  '1, SZ_WORD);
    wr(OFS_FSTA, '1, SZ_WORD);
    wr(OFS_ISTA, '1, SZ_WORD);
    wr('h1C,     '1, SZ_WORD);
    wr('h0D,     '1, SZ_WORD);
    rd(OFS_FSET, SZ_WORD, d); check("R7 fast mask kept", d, 32'h0000_0F00);
    rd(OFS_ISET, SZ_WORD, d); check("R7 normal mask kept", d, 32'h0000_0001);
    wr(OFS_FSET, '1, SZ_HALF);
    wr(OFS_ISET, '1, SZ_BYTE);
    wr(OFS_FCLR, '1, SZ_RSVD);
    rd(OFS_FSET, SZ_WORD, d); check("R8 fast mask kept after narrow writes", d, 32'h0000_0F00);
    rd(OFS_ISET, SZ_WORD, d); check("R8 normal mask kept after narrow writes", d, 32'h0000_0001);
    req_i = 32'h1234_5678;
    rd(OFS_RAW, SZ_HALF, d);  check("R8 halfword read zero", d, '0);
    rd(OFS_FSET, SZ_BYTE, d); check("R8 byte read zero", d, '0);
    req_i = '0;
  endtask

  initial begin
    t_reset();
    t_raw();
    t_set_masks();
    t_status_level();
    t_clear();
    t_irq_path();
    t_ignored();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule